// File: doc/BRIEF.md
# Two-Step Converter Bus Sequencer

This block is the digital control side of an 8-bit two-step converter, modelled synchronously to one clock. A microprocessor-style bus drives it with an active-low chip select, active-low read and write strobes, a mode select and a power-down request. The comparator banks are represented by two nibble inputs, `hi_nib` and `lo_nib`. The sequencer picks which strobe launches a conversion and times the upper and lower phases with programmable cycle counts. It captures each nibble into the output register at its own event, signals completion on an active-low interrupt, and enables the data bus only during a read access.

With `mode` low (read-launched mode), a read strobe falling while chip select is low starts the conversion. The result appears on the same read access. The shared strobe pin then acts as an open-drain ready flag, modelled as the drive-low enable `rdy_pull`. With `mode` high (write-launched mode), a falling write strobe arms the converter. The rising write strobe captures the upper nibble and starts the lower phase. The host later reads the full byte. All bus inputs are taken to be synchronous to `clk`.

Top module: `halfflash_seq`

## Requirements
- R1: With `mode`=0, `pwrdn`=0, the sequencer idle and awake, a read strobe falling edge while `cs_n` is low starts a conversion. Counting the launching clock edge as edge k, edge k+T_UPPER+T_LOWER loads `data_out` with {hi_nib, lo_nib} and drives `int_n` low.
- R2: With `mode`=0, a falling edge of `cs_n` sets `rdy_pull` (1 = pin pulled low) on the next cycle. The end of the conversion clears it on the same edge that drops `int_n`.
- R3: While `mode` is 1, `rdy_pull` stays 0.
- R4: After `int_n` has gone low, a rising edge of `cs_n` or of `rd_n` returns it high on the next cycle.
- R5: With `mode`=1, a write strobe falling edge while `cs_n` is low arms the sequencer. The following write strobe rising edge captures `hi_nib` into `data_out[7:4]` on that same edge. T_LOWER edges later, `lo_nib` is captured into `data_out[3:0]` and `int_n` goes low.
- R6: Each nibble is sampled only at its capture edge. Changes to `hi_nib` after the upper capture do not reach `data_out`. The lower nibble holds the value `lo_nib` had at the final edge.
- R7: `data_oe` is 1 exactly while both `cs_n` and `rd_n` are low, and 0 otherwise.
- R8: Asserting `pwrdn` abandons any conversion in progress. On the next cycle `int_n` is 1 and `rdy_pull` is 0, and the abandoned conversion never updates `data_out` or drops `int_n`.
- R9: After `pwrdn` falls, a launching strobe is ignored until `pwrdn` has been low for WAKE_CYC clock edges.
- R10: Strobe edges arriving while a conversion is running neither restart it nor change its completion edge.
- R11: Out of reset, `int_n`=1, `rdy_pull`=0 and `data_out`=0.
- R12: A read strobe falling edge while `cs_n` is high does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (used only when mode=1) |
| mode | input | 1 | 0 = read-launched, 1 = write-launched |
| pwrdn | input | 1 | Power-down request, active high |
| hi_nib | input | NIB_W | Upper comparator bank result |
| lo_nib | input | NIB_W | Lower comparator bank result |
| data_out | output | 2*NIB_W | Output register contents |
| data_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| int_n | output | 1 | End-of-conversion interrupt, active low |
| rdy_pull | output | 1 | Open-drain ready: 1 pulls the pin low, 0 releases it |

## Verification
Assertions check the following on every cycle:
- the interrupt falls on the cycle after the end-of-conversion event;
- a chip-select or read release raises it again;
- power-down releases both flags at once;
- the ready enable follows chip select and completion in read-launched mode and stays off in write-launched mode;
- no launch is accepted on the cycle after a power-down.

Only the bench scenarios can show the following:
- the exact conversion latency in each mode;
- which nibble value ends up in the register when the inputs move mid-conversion;
- that strobe edges during a busy phase leave the completion edge unchanged;
- that an aborted conversion leaves the old data in place;
- the full length of the wake-up window.

// File: rtl/hf_pkg.sv
package hf_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_UPPER = 2'd1,
    S_ARMED = 2'd2,
    S_LOWER = 2'd3
  } seq_st_t;

  // Counter preload so that a phase of n cycles ends on the n-th edge.
  function automatic int unsigned phase_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // Edges from the launching (or write-release) edge to completion.
  function automatic int unsigned conv_latency(input bit wr_mode,
                                               input int unsigned t_up,
                                               input int unsigned t_low);
    return wr_mode ? t_low : t_up + t_low;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/hf_strobe_edges.sv
module hf_strobe_edges #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev;

  // Strobes are active low, so the idle history is all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall[i] = prev[i] & ~lvl[i];
    assign rise[i] = ~prev[i] & lvl[i];
  end

endmodule

// File: rtl/hf_down_counter.sv
module hf_down_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (en && (cnt != '0))   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/halfflash_seq.sv
module halfflash_seq #(
  parameter int NIB_W    = 4,
  parameter int T_UPPER  = 4,
  parameter int T_LOWER  = 3,
  parameter int WAKE_CYC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               mode,
  input  logic               pwrdn,
  input  logic [NIB_W-1:0]   hi_nib,
  input  logic [NIB_W-1:0]   lo_nib,
  output logic [2*NIB_W-1:0] data_out,
  output logic               data_oe,
  output logic               int_n,
  output logic               rdy_pull
);
  import hf_pkg::*;

  localparam int PH_MAX = (T_UPPER > T_LOWER) ? T_UPPER : T_LOWER;
  localparam int PH_W   = cnt_width(PH_MAX);
  localparam int WK_W   = cnt_width(WAKE_CYC);
  localparam logic [PH_W-1:0] LD_UP  = PH_W'(phase_load(T_UPPER));
  localparam logic [PH_W-1:0] LD_LOW = PH_W'(phase_load(T_LOWER));
  localparam logic [WK_W-1:0] LD_WK  = WK_W'(WAKE_CYC);

  // Edge detection on the three strobes: bit 0 cs, bit 1 rd, bit 2 wr.
  logic [2:0] s_fall, s_rise;
  hf_strobe_edges #(.N(3)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({wr_n, rd_n, cs_n}),
    .fall (s_fall),
    .rise (s_rise)
  );

  wire cs_fall = s_fall[0];
  wire cs_rise = s_rise[0];
  wire rd_fall = s_fall[1];
  wire rd_rise = s_rise[1];
  wire wr_fall = s_fall[2];
  wire wr_rise = s_rise[2];

  seq_st_t st;

  // Named internal events
  logic ph_zero, wake_zero;
  logic [PH_W-1:0] ph_cnt;
  logic [WK_W-1:0] wk_cnt;

  wire idle_ok    = (st == S_IDLE) && !pwrdn && wake_zero;
  wire start_rd   = idle_ok && !mode && rd_fall && !cs_n;
  wire start_wr   = idle_ok &&  mode && wr_fall && !cs_n;
  wire start      = start_rd || start_wr;
  wire upper_done = (st == S_UPPER) && ph_zero && !pwrdn;
  wire wr_release = (st == S_ARMED) && wr_rise && !pwrdn;
  wire latch_hi   = upper_done || wr_release;
  wire conv_end   = (st == S_LOWER) && ph_zero && !pwrdn;

  hf_down_counter #(.W(PH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_rd || latch_hi),
    .load_val(start_rd ? LD_UP : LD_LOW),
    .en      ((st == S_UPPER) || (st == S_LOWER)),
    .cnt     (ph_cnt),
    .zero    (ph_zero)
  );

  hf_down_counter #(.W(WK_W)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pwrdn),
    .load_val(LD_WK),
    .en      (1'b1),
    .cnt     (wk_cnt),
    .zero    (wake_zero)
  );

  // Sequencer state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else if (pwrdn) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_IDLE:  if (start_rd) st <= S_UPPER;
                 else if (start_wr) st <= S_ARMED;
        S_UPPER: if (upper_done) st <= S_LOWER;
        S_ARMED: if (wr_release) st <= S_LOWER;
        S_LOWER: if (conv_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // Output register: each nibble has its own capture event.
  logic [2*NIB_W-1:0] data_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      if (latch_hi) data_q[2*NIB_W-1:NIB_W] <= hi_nib;
      if (conv_end) data_q[NIB_W-1:0]       <= lo_nib;
    end
  end

  // Interrupt and ready flags
  logic int_q, rdy_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b1;
      rdy_q <= 1'b0;
    end else begin
      if (pwrdn)                             int_q <= 1'b1;
      else if (conv_end)                     int_q <= 1'b0;
      else if (start || cs_rise || rd_rise)  int_q <= 1'b1;

      if (pwrdn || mode)                     rdy_q <= 1'b0;
      else if (cs_fall)                      rdy_q <= 1'b1;
      else if (conv_end || cs_rise)          rdy_q <= 1'b0;
    end
  end

  assign data_out = data_q;
  assign data_oe  = !cs_n && !rd_n;
  assign int_n    = int_q;
  assign rdy_pull = rdy_q;

  // Assertions
  a_r1_end_drops_int: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> !int_n);

  a_r2_rdy_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !mode && !pwrdn) |=> rdy_pull);

  a_r2_rdy_release: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && !cs_fall) |=> !rdy_pull);

  a_r3_no_rdy_in_wr_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) |-> !rdy_pull);

  a_r4_int_returns_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_rise || rd_rise) && !conv_end) |=> int_n);

  a_r8_pd_releases_flags: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> (int_n && !rdy_pull && (st == S_IDLE)));

  a_r9_no_start_after_pd: assert property (@(posedge clk) disable iff (!rst_n)
    ((WAKE_CYC > 0) && $past(pwrdn)) |-> !start);

endmodule

// File: tb/tb_halfflash_seq.sv
`timescale 1ns/1ps
module tb_halfflash_seq;

  localparam int NIB_W = 4;
  localparam int T_UP  = 4;
  localparam int T_LOW = 3;
  localparam int WAKE  = 6;
  // Negedge samples counted from the launch, inclusive of the completion edge.
  localparam int RD_LAT = T_UP + T_LOW + 1;
  localparam int WR_LAT = T_LOW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode = 1'b0, pwrdn = 1'b0;
  logic [NIB_W-1:0] hi_nib = '0, lo_nib = '0;
  logic [2*NIB_W-1:0] data_out;
  logic data_oe, int_n, rdy_pull;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  halfflash_seq #(.NIB_W(NIB_W), .T_UPPER(T_UP), .T_LOWER(T_LOW), .WAKE_CYC(WAKE)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .mode(mode),
    .pwrdn(pwrdn), .hi_nib(hi_nib), .lo_nib(lo_nib), .data_out(data_out),
    .data_oe(data_oe), .int_n(int_n), .rdy_pull(rdy_pull)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {mode, hi, lo}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 4'hA, 4'h5}, {1'b0, 4'h0, 4'h0}, {1'b0, 4'hF, 4'hF}, {1'b0, 4'h3, 4'hC},
    {1'b1, 4'h5, 4'hA}, {1'b1, 4'hF, 4'h0}, {1'b1, 4'h0, 4'hF}, {1'b1, 4'h9, 4'h6}
  };

  task automatic run_read(input logic [3:0] h, input logic [3:0] l);
    int lat;
    @(negedge clk); mode = 1'b0; hi_nib = h; lo_nib = l; cs_n = 1'b0; rd_n = 1'b0;
    lat = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); lat++;
      if (i == 0) chk("R2 ready pulled after select", rdy_pull, 1);
      if (!int_n) break;
    end
    chk("R1 read-mode latency", lat, RD_LAT);
    chk("R1 read-mode data", data_out, {h, l});
    chk("R2 ready released at end", rdy_pull, 0);
    chk("R7 bus enabled during read", data_oe, 1);
    rd_n = 1'b1;
    @(negedge clk);
    chk("R4 int high after read release", int_n, 1);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_wr(input logic [3:0] h, input logic [3:0] l);
    int lat;
    logic [3:0] l2;
    l2 = ~l;
    @(negedge clk); mode = 1'b1; hi_nib = h; lo_nib = l; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    lat = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); lat++;
      chk("R3 ready idle in write mode", rdy_pull, 0);
      if (i == 0) begin
        chk("R5 upper nibble on write release", data_out[7:4], h);
        hi_nib = ~h;   // R6: must not reach the register
        lo_nib = l2;   // R6: lower taken at the final edge
      end
      if (!int_n) break;
    end
    chk("R5 write-mode latency", lat, WR_LAT);
    chk("R6 nibble sampling points", data_out, {h, l2});
    cs_n = 1'b1;
    @(negedge clk);
    chk("R4 int high after select release", int_n, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 int after reset", int_n, 1);
    chk("R11 ready after reset", rdy_pull, 0);
    chk("R11 data after reset", data_out, 0);
    chk("R7 bus off while idle", data_oe, 0);

    // Table-driven conversions
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][8]) run_wr(VEC[v][7:4], VEC[v][3:0]);
      else           run_read(VEC[v][7:4], VEC[v][3:0]);
    end
    hi_nib = 4'h0; lo_nib = 4'h0;

    // R7 enable decode, in write mode so no conversion launches
    @(negedge clk); mode = 1'b1; cs_n = 1'b0; rd_n = 1'b1; #1;
    chk("R7 oe select only", data_oe, 0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R7 oe read only", data_oe, 0);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    chk("R7 oe both low", data_oe, 1);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); mode = 1'b0;
    @(negedge clk);

    // R12 read strobe without select
    held = data_out;
    rd_n = 1'b0;
    repeat (RD_LAT + 3) @(negedge clk);
    chk("R12 no start without select", int_n, 1);
    chk("R12 data unchanged", data_out, held);
    rd_n = 1'b1;
    @(negedge clk);

    // R10 strobe activity while busy
    hi_nib = 4'h6; lo_nib = 4'hB; cs_n = 1'b0; rd_n = 1'b0;
    lat = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); lat++;
      if (i == 1) rd_n = 1'b1;
      if (i == 2) rd_n = 1'b0;
      if (!int_n) break;
    end
    chk("R10 busy latency unchanged", lat, RD_LAT);
    chk("R10 busy data", data_out, 8'h6B);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);

    // R8 abort by power-down
    held = data_out;
    hi_nib = 4'h1; lo_nib = 4'h2; cs_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    pwrdn = 1'b1;
    @(negedge clk);
    chk("R8 int high in power-down", int_n, 1);
    chk("R8 ready released in power-down", rdy_pull, 0);
    repeat (RD_LAT + 3) @(negedge clk);
    chk("R8 aborted conversion never ends", int_n, 1);
    chk("R8 data kept", data_out, held);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);

    // R9 wake-up window
    pwrdn = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
    repeat (WAKE + RD_LAT + 2) @(negedge clk);
    chk("R9 launch ignored while waking", int_n, 1);
    chk("R9 data untouched while waking", data_out, held);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    run_read(4'hC, 4'h3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule